// File: doc/BRIEF.md
# Prescaled Timer Counter with Coherent Read

This block is a 16-bit up-counter that software reads through an 8-bit register bus. A 3-bit source field picks what advances the counter. Seven codes pick a power-of-two division of the bus clock, from one to sixty-four. The eighth code picks an external clock pin, which is synchronized and edge-detected inside the block. A control write can halt the counter or clear it to zero, and the clear also restarts the divider chain. When the counter rolls over from its top value it gives a one-cycle strobe that other logic can use.

Software reads the count one byte at a time. A read of the high byte captures the low byte in a holding register, and the next low-byte read returns that captured byte. The two halves therefore always come from the same instant. Further high-byte reads leave the held byte alone until the low byte is read. A debug-freeze input pauses counting and leaves the held byte untouched, so a read sequence begun while frozen still finishes coherently after the freeze ends.

Top module: `ptc_timer`

## Requirements
- R1: After reset the count reads 0x0000, the control register reads 0x00 (source code 000, not halted) and the overflow strobe is low.
- R2: With source code c from 0 to 6 in control bits [2:0] at address 0, the count rises by one every 2^c bus clocks, and never by more than one per clock.
- R3: Writing 1 to control bit 4 clears the count and the divider chain in that clock cycle. The next increment then comes a full 2^c clocks later. The bit reads back as 0.
- R4: While control bit 5 (halt) is 1, the count does not change.
- R5: A single control write with both bit 4 and bit 5 set leaves the count at 0x0000 and keeps it there.
- R6: A read at address 1 returns the live high byte and captures the low byte. The next read at address 2 returns the captured byte.
- R7: Further address-1 reads do not refresh the captured byte until address 2 has been read. After that, address-2 reads return the live low byte again.
- R8: While dbg_freeze is high the count holds. A low byte captured before or during the freeze is still returned after the freeze ends.
- R9: When the count advances from 0xFFFF it becomes 0x0000, and ovf_pulse is high for exactly the following cycle.
- R10: Source code 7 counts rising edges of ext_clk, after a two-flop synchronizer, with one count per edge.
- R11: Writes to addresses 1 and 2 do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address: 0 control, 1 count high, 2 count low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; its side effects take place at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| ext_clk | input | 1 | External count source; must run below half the bus clock |
| dbg_freeze | input | 1 | Debug freeze; pauses counting while high |
| ovf_pulse | output | 1 | One-cycle strobe after a wrap from 0xFFFF |

## Verification
Every divided source code is tried against a set of wait lengths that lie one clock below and exactly on multiples of its period. This separates a correct divide ratio from one that is off by a factor of two, and it catches a divider that is not reset by the clear. The read-latch tests place high-byte reads at counts where the live low byte has already moved away from the captured one, and a second high read between the pair shows whether it refreshes the held byte. A run that crosses the 0xFFFF boundary with a latched read pending tells the wrap and strobe timing apart from the latch behaviour. Edge trains on the external pin, with and without halt, check the synchronized source path.

// File: rtl/ptc_timer.sv
module ptc_timer #(
  parameter int PRE_STAGES = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       ext_clk,
  input  logic       dbg_freeze,
  output logic       ovf_pulse
);
  localparam int SRC_N = PRE_STAGES + 2;
  localparam int SEL_W = $clog2(SRC_N);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_HI   = 2'd1;
  localparam logic [1:0] A_LO   = 2'd2;

  logic [SEL_W-1:0]      sel_q;
  logic                  halt_q;
  logic [15:0]           cnt_q;
  logic [PRE_STAGES-1:0] div_q;
  logic [7:0]            hold_q;
  logic                  hold_v;
  logic [2:0]            ext_sy;
  logic                  ovf_q;
  logic [SRC_N-1:0]      tick_vec;

  wire ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  wire clr_req = ctrl_wr && bus_wdata[4];
  wire rd_hi   = bus_rd && (bus_addr == A_HI);
  wire rd_lo   = bus_rd && (bus_addr == A_LO);
  wire unused_wbits = ^{bus_wdata[7:6], bus_wdata[3]};

  assign tick_vec[0] = 1'b1;
  for (genvar k = 1; k <= PRE_STAGES; k++) begin : g_div
    assign tick_vec[k] = &div_q[k-1:0];
  end
  assign tick_vec[SRC_N-1] = ext_sy[1] & ~ext_sy[2];

  wire cnt_en = tick_vec[sel_q] & ~halt_q & ~dbg_freeze;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      halt_q <= 1'b0;
      cnt_q  <= '0;
      div_q  <= '0;
      hold_q <= '0;
      hold_v <= 1'b0;
      ext_sy <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        sel_q  <= bus_wdata[SEL_W-1:0];
        halt_q <= bus_wdata[5];
      end
      div_q  <= clr_req ? '0 : div_q + 1'b1;
      ext_sy <= {ext_sy[1:0], ext_clk};
      ovf_q  <= cnt_en && !clr_req && (&cnt_q);
      if (clr_req)     cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_q + 16'd1;
      if (rd_lo) hold_v <= 1'b0;
      else if (rd_hi && !hold_v) begin
        hold_q <= cnt_q[7:0];
        hold_v <= 1'b1;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {2'b00, halt_q, 2'b00, 3'(sel_q)};
      A_HI:    bus_rdata = cnt_q[15:8];
      A_LO:    bus_rdata = hold_v ? hold_q : cnt_q[7:0];
      default: bus_rdata = 8'h00;
    endcase
  end

  assign ovf_pulse = ovf_q;
endmodule

module ptc_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  bus_wdata,
  input logic        dbg_freeze,
  input logic [15:0] cnt_q,
  input logic        halt_q,
  input logic [7:0]  hold_q,
  input logic        hold_v,
  input logic        ovf_pulse
);
  wire c_wr  = bus_wr && (bus_addr == 2'd0);
  wire c_clr = c_wr && bus_wdata[4];
  wire c_rlo = bus_rd && (bus_addr == 2'd2);

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) c_clr |=> (cnt_q == 16'h0000)); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n) !c_clr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 16'd1)); // R2
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (halt_q && !c_wr) |=> $stable(cnt_q)); // R4
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (dbg_freeze && !c_wr) |=> $stable(cnt_q)); // R8
  AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (hold_v && !c_rlo) |=> (hold_v && $stable(hold_q))); // R7
  AST_OVF_ZERO: assert property (@(posedge clk) disable iff (!rst_n) ovf_pulse |-> (cnt_q == 16'h0000)); // R9
  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ovf_pulse |=> !ovf_pulse); // R9
endmodule

bind ptc_timer ptc_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .dbg_freeze(dbg_freeze), .cnt_q(cnt_q), .halt_q(halt_q),
  .hold_q(hold_q), .hold_v(hold_v), .ovf_pulse(ovf_pulse)
);

// File: tb/tb_ptc_timer.sv
module tb_ptc_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic ext_clk = 1'b0, dbg_freeze = 1'b0;
  logic ovf_pulse;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ptc_timer dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
                 .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
                 .dbg_freeze(dbg_freeze), .ovf_pulse(ovf_pulse));

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] h, l;
    int ns[7] = '{0, 1, 7, 8, 63, 64, 500};
    repeat (3) @(negedge clk);
    bus_addr = 2'd0; #1 chk("R1 ctrl", bus_rdata, 0);
    bus_addr = 2'd1; #1 chk("R1 hi", bus_rdata, 0);
    bus_addr = 2'd2; #1 chk("R1 lo", bus_rdata, 0);
    chk("R1 ovf", ovf_pulse, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 / R3: divided sources, each started by a clear
    for (int s = 0; s < 7; s++) begin
      for (int i = 0; i < 7; i++) begin
        wr(2'd0, 8'(s) | 8'h10);
        wait_n(ns[i]);
        rd(2'd1, h); rd(2'd2, l);
        chk($sformatf("R2 sel=%0d n=%0d", s, ns[i]), {h, l}, ns[i] >> s);
      end
    end
    wr(2'd0, 8'h13);
    rd(2'd0, h); chk("R3 clr bit reads 0", h, 8'h03);

    // R4 halt
    wr(2'd0, 8'h10); wait_n(40);
    wr(2'd0, 8'h20);
    rd(2'd1, h); rd(2'd2, l);
    wait_n(50);
    rd(2'd2, l); chk("R4 halt hold", l, 41);
    chk("R4 halt hi", h, 0);

    // R5 halt with clear
    wr(2'd0, 8'h00); wait_n(30);
    wr(2'd0, 8'h30); wait_n(25);
    rd(2'd1, h); rd(2'd2, l);
    chk("R5 halt+clr", {h, l}, 0);

    // R6 / R7 coherent read, repeated high read
    wr(2'd0, 8'h10); wait_n(300);
    rd(2'd1, h); chk("R6 hi", h, 1);
    wait_n(10);
    rd(2'd1, h); chk("R7 second hi", h, 1);
    rd(2'd2, l); chk("R7 held lo", l, 300 & 255);
    rd(2'd2, l); chk("R7 released lo", l, 313 & 255);

    // R8 freeze
    wr(2'd0, 8'h10); wait_n(100);
    dbg_freeze = 1'b1;
    rd(2'd1, h); rd(2'd2, l); chk("R8 freeze lo", l, 100);
    wait_n(20);
    rd(2'd1, h); rd(2'd2, l); chk("R8 frozen", {h, l}, 100);
    rd(2'd1, h);
    dbg_freeze = 1'b0;
    wait_n(5);
    rd(2'd2, l); chk("R8 latch past freeze", l, 100);
    rd(2'd2, l); chk("R8 resumed", l, 106);

    // R10 external source
    wr(2'd0, 8'h17);
    for (int e = 0; e < 37; e++) begin
      ext_clk = 1'b1; wait_n(4); ext_clk = 1'b0; wait_n(4);
    end
    wait_n(6);
    rd(2'd1, h); rd(2'd2, l); chk("R10 ext edges", {h, l}, 37);
    wr(2'd0, 8'h27);
    for (int e = 0; e < 5; e++) begin
      ext_clk = 1'b1; wait_n(4); ext_clk = 1'b0; wait_n(4);
    end
    wait_n(6);
    rd(2'd2, l); chk("R4 ext halted", l, 37);

    // R11 writes to count addresses
    wr(2'd1, 8'hAA); wr(2'd2, 8'h55);
    rd(2'd1, h); rd(2'd2, l); chk("R11 write ignored", {h, l}, 37);

    // R9 wrap
    wr(2'd0, 8'h10); wait_n(65535);
    chk("R9 ovf before wrap", ovf_pulse, 0);
    rd(2'd1, h); chk("R9 hi at top", h, 8'hFF);
    chk("R9 ovf strobe", ovf_pulse, 1);
    rd(2'd2, l); chk("R6 lo captured at top", l, 8'hFF);
    chk("R9 ovf single", ovf_pulse, 0);
    rd(2'd1, h); chk("R9 wrapped hi", h, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule